// File: doc/BRIEF.md
# Time-tagged bus monitor logger

This block sits behind a serial-bus word decoder and records received wordstrings into a ring buffer held in an external synchronous memory. A wordstring arrives as a label word followed by zero or more data words. Each word comes with a valid strobe, first/last markers and two error flags. A stored record holds the label word, the data words in arrival order, a 40-bit time stamp split over three words, and a 16-bit status word.

A free-running time-tag counter supplies the stamp. It advances once every `TICK_DIV` clocks, which gives 0.5 µs steps at a 32 MHz clock. A host command or a rising edge on the trigger input clears it. A label filter decides which wordstrings are kept. In one mode every wordstring is kept, including ones the local transmitter sent. In the other mode only labels whose bit is set in a 4096-entry enable map are kept.

The host reads records from the ring. It publishes its read pointer, and it learns how far the log has been filled from the committed write pointer. In continuous mode the ring simply wraps at a programmable depth. In one-shot mode the capture is armed, starts on the trigger and stops for good at the first record that no longer fits.

Top module: `tagmon_logger`

## Requirements
- R1: The time tag is a 40-bit counter that rises by exactly one every `TICK_DIV` clock cycles and wraps to zero after all ones.
- R2: A high `tag_clr`, or a rising edge of `trig_in` (high now, low in the previous cycle), makes the time tag zero in the following cycle and restarts its prescaler; the counter then reads floor(j/`TICK_DIV`) j cycles after the clearing edge.
- R3: A record is written one word per cycle at consecutive ring addresses starting at `wr_ptr`, wrapping to 0 at `cfg_depth`. The order is the label word, the data words, then the time words (high word holds stamp bits 39:32 zero-extended, then bits 31:16, then bits 15:0), then the status word. Each label or data word appears on the memory port the cycle after it is accepted, and the four trailer words follow on the four cycles after the last word. The source must keep `w_valid` low during those four trailer cycles.
- R4: The stored time stamp is the counter value held in the cycle in which the label word is accepted.
- R5: Status bit 0 is the OR of the parity flags over the wordstring, bit 1 the OR of the Manchester/sync flags, bit 2 is set when the data-word count is below `cfg_min_words`, bit 3 is the lost-record flag of R8, bits 7:4 are zero and bits 15:8 hold the data-word count.
- R6: The label is `w_data[15:4]`. With `cfg_all` high every wordstring is kept. With it low, only labels whose enable-map bit is set are kept; `flt_we` writes `flt_en` into the bit for `flt_label`. A rejected wordstring causes no memory write.
- R7: `wr_ptr` changes only in the cycle the status word is written, and then it moves to the address just past that word.
- R8: Free space is `cfg_depth`-1 minus the unread words between `rd_ptr` and `wr_ptr`. The word at record offset k (label at 0) is written only if k+4 is below the free space. Otherwise the record is abandoned: no further writes, `wr_ptr` unchanged, and status bit 3 is set in the next committed record.
- R9: With `cfg_oneshot` high, nothing is stored until `arm` has been pulsed and a trigger edge follows. The first abandoned record then ends the capture: `cap_done` rises, `cap_active` falls, and later wordstrings are not stored until the next `arm`.
- R10: A word received with `w_first` low outside a wordstring is ignored.
- R11: After reset `wr_ptr` is 0, the enable map is cleared, no memory write is issued, `cap_done` is low, and `cap_active` is high in continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_clr | input | 1 | Host command: clear the time tag |
| trig_in | input | 1 | External trigger; rising edge clears the tag and starts an armed capture |
| cfg_all | input | 1 | 1: keep every wordstring; 0: keep only enabled labels |
| cfg_oneshot | input | 1 | 1: one-shot capture; 0: continuous ring |
| cfg_depth | input | AW+1 | Ring depth in words (2 to 2^AW) |
| cfg_min_words | input | 8 | Data-word count below which the short-string bit is set |
| arm | input | 1 | Arms a one-shot capture |
| flt_we | input | 1 | Enable-map write strobe |
| flt_label | input | LBL_W | Enable-map entry to write |
| flt_en | input | 1 | Value written into the enable map |
| w_valid | input | 1 | Received word strobe |
| w_first | input | 1 | Word is a label word (starts a wordstring) |
| w_last | input | 1 | Word ends the wordstring |
| w_data | input | DW | Received word |
| w_par_err | input | 1 | Parity error on this word |
| w_man_err | input | 1 | Manchester or sync error on this word |
| rd_ptr | input | AW | Host read pointer (next unread word) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| wr_ptr | output | AW | Committed write pointer |
| cap_active | output | 1 | Wordstrings are currently being captured |
| cap_done | output | 1 | One-shot capture has ended |

## Verification
Each label or data word is due on the memory port one cycle after the edge that accepts it. The four trailer words are due one to four cycles after the last word, and the write pointer moves with the status word. A time stamp equals the number of whole `TICK_DIV` periods between the clearing edge and the cycle before the label's edge. The driver predicts every write and its address before it drives a wordstring. The monitor compares memory writes at the falling edge, one per cycle in order, so each compare lands on the cycle the write is due. The pointer, filter, one-shot and lost-record checks are taken six idle cycles after the last word, once the trailer must have finished.

// File: rtl/tagmon_pkg.sv
package tagmon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BODY,
    ST_TRAIL,
    ST_SKIP
  } rec_state_e;

  typedef struct packed {
    logic [7:0] cnt;
    logic [3:0] rsv;
    logic       lost;
    logic       short_s;
    logic       man_err;
    logic       par_err;
  } rec_stat_t;

  localparam int unsigned TRAIL_WORDS = 4;

  // Next ring address, wrapping at the programmed depth.
  function automatic int unsigned ring_step(int unsigned p, int unsigned d);
    return (p + 1 >= d) ? 0 : p + 1;
  endfunction

  // Words that may still be written without reaching the reader.
  function automatic int unsigned ring_free(int unsigned wr, int unsigned rd,
                                            int unsigned d);
    int unsigned used;
    if (d == 0) return 0;
    used = (wr >= rd) ? wr - rd : wr + d - rd;
    return (used + 1 >= d) ? 0 : d - 1 - used;
  endfunction

  // A word at record offset off is allowed only if the trailer still fits.
  function automatic logic word_fits(int unsigned off, int unsigned free);
    return (off + TRAIL_WORDS) < free;
  endfunction

endpackage

// File: rtl/tagmon_timetag.sv
module tagmon_timetag #(
  parameter int TS_W     = 40,
  parameter int TICK_DIV = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  output logic [TS_W-1:0] tag
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0] pre;
  logic             tick;

  assign tick = (32'(pre) == TICK_DIV - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      tag <= '0;
    end else if (clr) begin
      pre <= '0;
      tag <= '0;
    end else if (tick) begin
      pre <= '0;
      tag <= tag + TS_W'(1);
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end

  // R2
  tt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tag == '0));

  // R1
  tt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (tag == $past(tag) || tag == $past(tag) + TS_W'(1)));

endmodule

// File: rtl/tagmon_filter.sv
module tagmon_filter #(
  parameter int LBL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_we,
  input  logic [LBL_W-1:0] flt_label,
  input  logic             flt_en,
  input  logic             cfg_all,
  input  logic [LBL_W-1:0] q_label,
  output logic             hit
);
  localparam int NLBL = 1 << LBL_W;

  logic [NLBL-1:0] enable_map;

  always_ff @(posedge clk) begin
    if (!rst_n) enable_map <= '0;
    else if (flt_we) enable_map[flt_label] <= flt_en;
  end

  assign hit = cfg_all | enable_map[q_label];

endmodule

// File: rtl/tagmon_space.sv
module tagmon_space
  import tagmon_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_ptr,
  input  logic [AW:0]   depth,
  output logic [AW:0]   free
);
  localparam int PW = AW + 1;

  assign free = PW'(ring_free(32'(wr_ptr), 32'(rd_ptr), 32'(depth)));

endmodule

// File: rtl/tagmon_logger.sv
module tagmon_logger
  import tagmon_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int LBL_W    = 12,
  parameter int TS_W     = 40,
  parameter int TICK_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_clr,
  input  logic             trig_in,
  input  logic             cfg_all,
  input  logic             cfg_oneshot,
  input  logic [AW:0]      cfg_depth,
  input  logic [7:0]       cfg_min_words,
  input  logic             arm,
  input  logic             flt_we,
  input  logic [LBL_W-1:0] flt_label,
  input  logic             flt_en,
  input  logic             w_valid,
  input  logic             w_first,
  input  logic             w_last,
  input  logic [DW-1:0]    w_data,
  input  logic             w_par_err,
  input  logic             w_man_err,
  input  logic [AW-1:0]    rd_ptr,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [AW-1:0]    wr_ptr,
  output logic             cap_active,
  output logic             cap_done
);
  localparam int PW    = AW + 1;
  localparam int EXT_W = DW - LBL_W;

  // Named internal events
  logic            trig_q;
  logic            trig_evt;
  logic            tag_clr_evt;
  logic [TS_W-1:0] tag_now;
  logic            flt_hit;
  logic [PW-1:0]   space_free;
  logic            cap_en;
  logic            start_hit;
  logic            take_word;
  logic            word_ok;
  logic            wr_word;
  logic            drop_now;
  logic            commit;
  logic            trail_busy;

  rec_state_e      st;
  logic [AW-1:0]   cursor;
  logic [PW-1:0]   off;
  logic [PW-1:0]   dcnt;
  logic [1:0]      tcnt;
  logic [TS_W-1:0] ts_q;
  logic            acc_par, acc_man, lost;
  logic            armed, active, done;
  rec_stat_t       stat_w;
  logic [DW-1:0]   trail_word;
  logic [PW-1:0]   off_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_in;
  end

  assign trig_evt    = trig_in & ~trig_q;
  assign tag_clr_evt = tag_clr | trig_evt;

  tagmon_timetag #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) u_timetag (
    .clk(clk), .rst_n(rst_n), .clr(tag_clr_evt), .tag(tag_now)
  );

  tagmon_filter #(.LBL_W(LBL_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .flt_we(flt_we), .flt_label(flt_label),
    .flt_en(flt_en), .cfg_all(cfg_all), .q_label(w_data[DW-1:EXT_W]),
    .hit(flt_hit)
  );

  tagmon_space #(.AW(AW)) u_space (
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .depth(cfg_depth), .free(space_free)
  );

  assign cap_en     = !cfg_oneshot || active;
  assign start_hit  = w_valid && w_first && (st == ST_IDLE) && cap_en && flt_hit;
  assign take_word  = start_hit || ((st == ST_BODY) && w_valid);
  assign off_sel    = (st == ST_IDLE) ? '0 : off;
  assign word_ok    = word_fits(32'(off_sel), 32'(space_free));
  assign wr_word    = take_word && word_ok;
  assign drop_now   = take_word && !word_ok;
  assign trail_busy = (st == ST_TRAIL);
  assign commit     = trail_busy && (tcnt == 2'd3);

  always_comb begin
    stat_w.cnt     = 8'(dcnt);
    stat_w.rsv     = '0;
    stat_w.lost    = lost;
    stat_w.short_s = 32'(dcnt) < 32'(cfg_min_words);
    stat_w.man_err = acc_man;
    stat_w.par_err = acc_par;
  end

  always_comb begin
    unique case (tcnt)
      2'd0:    trail_word = DW'(ts_q[TS_W-1:2*DW]);
      2'd1:    trail_word = ts_q[2*DW-1:DW];
      2'd2:    trail_word = ts_q[DW-1:0];
      default: trail_word = DW'(stat_w);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cursor    <= '0;
      off       <= '0;
      dcnt      <= '0;
      tcnt      <= '0;
      ts_q      <= '0;
      acc_par   <= 1'b0;
      acc_man   <= 1'b0;
      lost      <= 1'b0;
      armed     <= 1'b0;
      active    <= 1'b0;
      done      <= 1'b0;
      wr_ptr    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;

      if (arm) begin
        armed  <= 1'b1;
        active <= 1'b0;
        done   <= 1'b0;
      end else if (trig_evt && armed) begin
        armed  <= 1'b0;
        active <= 1'b1;
      end

      unique case (st)
        ST_IDLE: begin
          if (w_valid && w_first) begin
            if (start_hit) begin
              ts_q    <= tag_now;
              acc_par <= w_par_err;
              acc_man <= w_man_err;
              dcnt    <= '0;
            end
            if (wr_word) begin
              mem_we    <= 1'b1;
              mem_addr  <= wr_ptr;
              mem_wdata <= w_data;
              cursor    <= AW'(ring_step(32'(wr_ptr), 32'(cfg_depth)));
              off       <= PW'(1);
              tcnt      <= '0;
              st        <= w_last ? ST_TRAIL : ST_BODY;
            end else begin
              st <= w_last ? ST_IDLE : ST_SKIP;
            end
          end
        end
        ST_BODY: begin
          if (w_valid) begin
            acc_par <= acc_par | w_par_err;
            acc_man <= acc_man | w_man_err;
            if (wr_word) begin
              mem_we    <= 1'b1;
              mem_addr  <= cursor;
              mem_wdata <= w_data;
              cursor    <= AW'(ring_step(32'(cursor), 32'(cfg_depth)));
              off       <= off + PW'(1);
              dcnt      <= dcnt + PW'(1);
              tcnt      <= '0;
              st        <= w_last ? ST_TRAIL : ST_BODY;
            end else begin
              st <= w_last ? ST_IDLE : ST_SKIP;
            end
          end
        end
        ST_TRAIL: begin
          mem_we    <= 1'b1;
          mem_addr  <= cursor;
          mem_wdata <= trail_word;
          cursor    <= AW'(ring_step(32'(cursor), 32'(cfg_depth)));
          tcnt      <= tcnt + 2'd1;
          if (commit) begin
            wr_ptr <= AW'(ring_step(32'(cursor), 32'(cfg_depth)));
            lost   <= 1'b0;
            st     <= ST_IDLE;
          end
        end
        ST_SKIP: begin
          if (w_valid && w_last) st <= ST_IDLE;
        end
      endcase

      if (drop_now) begin
        lost <= 1'b1;
        if (cfg_oneshot) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign cap_active = cap_en;
  assign cap_done   = done;

  // R3
  mem_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (32'(mem_addr) < 32'(cfg_depth)));

  // R3 (source keeps quiet while the trailer is written)
  trail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_busy |-> !w_valid);

  // R7
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_ptr) |-> $past(commit));

  // R8
  lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_now |=> lost);

  // R9
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_oneshot && cap_done) |-> !cap_active);

endmodule

// File: tb/tagmon_logger_bench.sv
module tagmon_logger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 8;
  localparam int DIV   = 16;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n, tag_clr, trig_in, cfg_all, cfg_oneshot, arm;
  logic [AW:0] cfg_depth;
  logic [7:0]  cfg_min_words;
  logic        flt_we, flt_en;
  logic [11:0] flt_label;
  logic        w_valid, w_first, w_last, w_par_err, w_man_err;
  logic [15:0] w_data;
  logic [AW-1:0] rd_ptr;
  logic        mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [AW-1:0] wr_ptr;
  logic        cap_active, cap_done;

  tagmon_logger u_tagmon_logger (
    .clk(clk), .rst_n(rst_n), .tag_clr(tag_clr), .trig_in(trig_in),
    .cfg_all(cfg_all), .cfg_oneshot(cfg_oneshot), .cfg_depth(cfg_depth),
    .cfg_min_words(cfg_min_words), .arm(arm), .flt_we(flt_we),
    .flt_label(flt_label), .flt_en(flt_en), .w_valid(w_valid),
    .w_first(w_first), .w_last(w_last), .w_data(w_data),
    .w_par_err(w_par_err), .w_man_err(w_man_err), .rd_ptr(rd_ptr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_ptr(wr_ptr), .cap_active(cap_active), .cap_done(cap_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          addr;
    logic [15:0] data;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          checks = 0;
  int          fails  = 0;
  int unsigned ecnt   = 0;
  int          clr_e  = 0;
  int          bwr = 0, rdm = 0, minw = 2;
  bit          b_all = 1, b_one = 0, b_armed = 0, b_active = 0, b_done = 0, b_lost = 0;
  bit          bmap[int];
  string       ts_tag = "R4";
  string       st_tag = "R5";

  always @(posedge clk) ecnt <= ecnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int addr, input logic [15:0] d, input string tg);
    exp_t e;
    e.addr = addr; e.data = d; e.tag = tg;
    sbq.push_back(e);
  endtask

  // Monitor: compares each memory write against the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R3", "unexpected write", {mem_addr, mem_wdata}, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(mem_addr == AW'(e.addr) && mem_wdata == e.data, e.tag,
              "memory write {addr,data}", {mem_addr, mem_wdata},
              {8'(e.addr), e.data});
      end
    end
  end

  function automatic logic [15:0] wordv(input logic [11:0] lbl, input int k);
    if (k == 0) return {lbl, 4'h5};
    return 16'(({lbl[7:0], 8'h00} ^ 16'h5A00) + k);
  endfunction

  task automatic clear_tag();
    @(negedge clk); tag_clr = 1'b1; clr_e = int'(ecnt) + 1;
    @(negedge clk); tag_clr = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1; clr_e = int'(ecnt) + 1;
    if (b_one && b_armed) begin b_armed = 0; b_active = 1; end
    @(negedge clk); trig_in = 1'b0;
  endtask

  task automatic set_rd(input int v);
    @(negedge clk); rd_ptr = AW'(v); rdm = v;
  endtask

  task automatic send_str(input logic [11:0] lbl, input int n, input bit perr,
                          input bit merr, input string rq);
    bit     store;
    int     used, free;
    longint ts;
    logic [15:0] stw;
    store = (!b_one || b_active) && (b_all || (bmap.exists(int'(lbl)) && bmap[int'(lbl)]));
    used  = (bwr - rdm + DEPTH) % DEPTH;
    free  = DEPTH - 1 - used;
    @(negedge clk);
    ts = longint'((int'(ecnt) - clr_e) / DIV);
    if (store) begin
      for (int k = 0; k <= n; k++)
        if (k + 4 < free) push((bwr + k) % DEPTH, wordv(lbl, k), "R3");
      if (n + 5 <= free) begin
        stw = {8'(n), 4'b0, b_lost, (n < minw), merr, perr};
        push((bwr + n + 1) % DEPTH, {8'h00, 8'(ts >> 32)}, ts_tag);
        push((bwr + n + 2) % DEPTH, 16'(ts >> 16), ts_tag);
        push((bwr + n + 3) % DEPTH, 16'(ts), ts_tag);
        push((bwr + n + 4) % DEPTH, stw, st_tag);
        bwr = (bwr + n + 5) % DEPTH;
        b_lost = 0;
      end else begin
        b_lost = 1;
        if (b_one) begin b_active = 0; b_done = 1; end
      end
    end
    for (int i = 0; i <= n; i++) begin
      if (i > 0) @(negedge clk);
      w_valid   = 1'b1;
      w_first   = (i == 0);
      w_last    = (i == n);
      w_data    = wordv(lbl, i);
      w_par_err = perr && (i == n);
      w_man_err = merr && (i == 0);
    end
    @(negedge clk);
    w_valid = 1'b0; w_first = 1'b0; w_last = 1'b0;
    w_par_err = 1'b0; w_man_err = 1'b0;
    repeat (6) @(negedge clk);
    check(wr_ptr == AW'(bwr), rq, "wr_ptr after wordstring", wr_ptr, bwr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tag_clr = 1'b0; trig_in = 1'b0; cfg_all = 1'b1;
    cfg_oneshot = 1'b0; arm = 1'b0; cfg_depth = (AW+1)'(DEPTH);
    cfg_min_words = 8'(minw); flt_we = 1'b0; flt_en = 1'b0; flt_label = '0;
    w_valid = 1'b0; w_first = 1'b0; w_last = 1'b0; w_data = '0;
    w_par_err = 1'b0; w_man_err = 1'b0; rd_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(wr_ptr == '0, "R11", "wr_ptr", wr_ptr, 0);
    check(mem_we == 1'b0, "R11", "mem_we", mem_we, 0);
    check(cap_done == 1'b0, "R11", "cap_done", cap_done, 0);
    check(cap_active == 1'b1, "R11", "cap_active", cap_active, 1);

    // R4: stamp taken at label word, right after a clear
    clear_tag();
    ts_tag = "R4";
    send_str(12'h0A1, 2, 1'b0, 1'b0, "R7");
    set_rd(bwr);

    // R1: several tick periods elapse before the label
    clear_tag();
    repeat (3*DIV + 5) @(negedge clk);
    ts_tag = "R1";
    send_str(12'h0A2, 3, 1'b0, 1'b0, "R7");
    set_rd(bwr);

    // R5: error flags and short strings
    ts_tag = "R4";
    send_str(12'h0B0, 1, 1'b1, 1'b1, "R5");
    send_str(12'h0B1, 0, 1'b0, 1'b0, "R5");
    set_rd(bwr);

    // R10: data word outside a wordstring
    @(negedge clk);
    w_valid = 1'b1; w_first = 1'b0; w_last = 1'b1; w_data = 16'hBEEF;
    @(negedge clk);
    w_valid = 1'b0; w_last = 1'b0;
    repeat (6) @(negedge clk);
    check(wr_ptr == AW'(bwr), "R10", "wr_ptr after stray word", wr_ptr, bwr);

    // R6: label filter
    @(negedge clk); cfg_all = 1'b0; b_all = 0;
    send_str(12'h123, 2, 1'b0, 1'b0, "R6");
    @(negedge clk); flt_we = 1'b1; flt_label = 12'h123; flt_en = 1'b1; bmap[12'h123] = 1;
    @(negedge clk); flt_we = 1'b0;
    send_str(12'h123, 2, 1'b0, 1'b0, "R6");
    send_str(12'h122, 1, 1'b0, 1'b0, "R6");
    set_rd(bwr);
    @(negedge clk); cfg_all = 1'b1; b_all = 1;

    // R2: external trigger clears the tag
    pulse_trig();
    repeat (DIV + 2) @(negedge clk);
    ts_tag = "R2";
    send_str(12'h0C0, 1, 1'b0, 1'b0, "R7");
    set_rd(bwr);
    ts_tag = "R4";

    // R8: ring nearly full, one record abandoned part way
    set_rd((bwr + 14) % DEPTH);
    send_str(12'h0D0, 3, 1'b0, 1'b0, "R8");
    send_str(12'h0D1, 2, 1'b0, 1'b0, "R8");
    set_rd(bwr);
    st_tag = "R8";
    send_str(12'h0D2, 1, 1'b0, 1'b0, "R8");
    st_tag = "R5";
    set_rd(bwr);

    // R9: one-shot capture
    @(negedge clk); cfg_oneshot = 1'b1; b_one = 1;
    @(negedge clk);
    check(cap_active == 1'b0, "R9", "cap_active before arm", cap_active, 0);
    send_str(12'h0E0, 1, 1'b0, 1'b0, "R9");
    @(negedge clk); arm = 1'b1; b_armed = 1; b_done = 0;
    @(negedge clk); arm = 1'b0;
    send_str(12'h0E1, 1, 1'b0, 1'b0, "R9");
    pulse_trig();
    @(negedge clk);
    check(cap_active == 1'b1, "R9", "cap_active after trigger", cap_active, 1);
    send_str(12'h0E2, 4, 1'b0, 1'b0, "R9");
    send_str(12'h0E3, 4, 1'b0, 1'b0, "R9");
    send_str(12'h0E4, 4, 1'b0, 1'b0, "R9");
    send_str(12'h0E5, 4, 1'b0, 1'b0, "R9");
    check(cap_done == 1'b1, "R9", "cap_done when full", cap_done, 1);
    check(cap_active == 1'b0, "R9", "cap_active when full", cap_active, 0);
    set_rd(bwr);
    send_str(12'h0E6, 0, 1'b0, 1'b0, "R9");

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R3", "writes still expected", sbq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule